// File: doc/BRIEF.md
# Secondary Interrupt Combiner with Direct Routing

This block gathers up to 32 level-sensitive interrupt requests and presents them to a primary vectored interrupt controller. Each cycle it samples the request inputs, gates them with a software-owned enable mask, and ORs the surviving requests into one summary line. That line drives a fixed input of the primary controller.

A second enable register lets each request line in the band 21 to 30 bypass the combiner. Each such line can drive the primary controller input of the same number on its own. A software interrupt flag sits on bit 0 of the request vector, so firmware can raise a request with no hardware source behind it.

Software reaches the block through a plain 32-bit register port with read and write strobes. The port decodes a 4 KB window by word index. All outputs, including read data, are registered.

Top module: `sec_irq_ctrl`

## Requirements
- R1: After synchronous reset, every output line, the read data, the enable mask, the routing enable register and the software flag are zero.
- R2: The word index is taken from address bits [11:2]; bits [1:0] are ignored. A read at index 1 returns the effective request vector, index 0 returns that vector ANDed with the enable mask, and index 2 returns the enable mask. Read data appears on `bus_rdata` one clock after the read strobe and holds until the next read.
- R3: A write at index 2 ORs the write data into the enable mask.
- R4: A write at index 3 clears each enable mask bit that is set in the write data.
- R5: Output line 31 is high exactly when the effective request vector ANDed with the enable mask is non-zero. It updates one clock after the input or register change that causes it.
- R6: A write at index 8 ORs `wdata & 0x7FE00000` into the routing enable register, so only bits 21 to 30 can be set. A read at index 8 returns that register.
- R7: A write at index 9 clears each routing enable bit that is set in the write data. A line whose routing bit is cleared drops low one clock after the write.
- R8: Each output line from 21 to 30 whose routing bit is set equals its request input as sampled one clock earlier. Routed lines with a clear bit, and lines 0 to 20, are always low.
- R9: A non-zero write at index 4 sets the software flag and a non-zero write at index 5 clears it. A zero write to either index has no effect. A read at index 4 returns the flag in bit 0 and zero in all other bits.
- R10: The software flag is ORed into bit 0 of the effective request vector. It therefore shows in the raw and masked reads and can drive line 31.
- R11: Reads at any other index return zero. Writes at any other index, including the read-only indices 0 and 1, change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Level-sensitive request inputs |
| bus_addr | input | 12 | Byte address within the register window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 32 | Lines to the primary controller (31 = summary, 21..30 = routed) |

## Verification
A corrupt enable mask or software flag shows on summary line 31 in the cycle after the next request change. It also shows in the masked read one clock after the read strobe. A routing register bit set outside 21..30, or left set after a clear, puts a high level on an output line that must stay low, one clock after the matching request rises. A write decoded at the wrong index shows in the next read-back of the mask, routing or flag word.

// File: rtl/sic_pkg.sv
package sic_pkg;
  // Word indices decoded from address bits [11:2]
  localparam int IDX_MASKED   = 0;
  localparam int IDX_RAW      = 1;
  localparam int IDX_EN_SET   = 2;
  localparam int IDX_EN_CLR   = 3;
  localparam int IDX_SOFT_SET = 4;
  localparam int IDX_SOFT_CLR = 5;
  localparam int IDX_RT_SET   = 8;
  localparam int IDX_RT_CLR   = 9;
endpackage

// File: rtl/sic_regs.sv
module sic_regs
  import sic_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int IDX_W   = 10,
  parameter int RT_LO   = 21,
  parameter int RT_HI   = 30
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [N_LINES-1:0] wr_data,
  output logic [N_LINES-1:0] mask_q,
  output logic [N_LINES-1:0] rt_q,
  output logic               soft_q,
  output logic [N_LINES-1:0] mask_nxt,
  output logic [N_LINES-1:0] rt_nxt,
  output logic               soft_nxt
);
  function automatic logic [N_LINES-1:0] band_mask();
    logic [N_LINES-1:0] m;
    m = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (i >= RT_LO && i <= RT_HI) m[i] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [N_LINES-1:0] RT_ALLOW = band_mask();

  logic data_nz;
  assign data_nz = |wr_data;

  always_comb begin
    mask_nxt = mask_q;
    rt_nxt   = rt_q;
    soft_nxt = soft_q;
    if (wr_en) begin
      if (wr_idx == IDX_W'(IDX_EN_SET))        mask_nxt = mask_q | wr_data;
      else if (wr_idx == IDX_W'(IDX_EN_CLR))   mask_nxt = mask_q & ~wr_data;
      else if (wr_idx == IDX_W'(IDX_SOFT_SET)) soft_nxt = soft_q | data_nz;
      else if (wr_idx == IDX_W'(IDX_SOFT_CLR)) soft_nxt = soft_q & ~data_nz;
      else if (wr_idx == IDX_W'(IDX_RT_SET))   rt_nxt   = rt_q | (wr_data & RT_ALLOW);
      else if (wr_idx == IDX_W'(IDX_RT_CLR))   rt_nxt   = rt_q & ~wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      rt_q   <= '0;
      soft_q <= 1'b0;
    end else begin
      mask_q <= mask_nxt;
      rt_q   <= rt_nxt;
      soft_q <= soft_nxt;
    end
  end
endmodule

// File: rtl/sic_route.sv
module sic_route #(
  parameter int N_LINES  = 32,
  parameter int SUM_LINE = 31
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] lvl_nxt,
  input  logic [N_LINES-1:0] mask_nxt,
  input  logic [N_LINES-1:0] rt_nxt,
  output logic [N_LINES-1:0] irq_out
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    if (g == SUM_LINE) begin : g_sum
      always_ff @(posedge clk) begin
        if (rst) irq_out[g] <= 1'b0;
        else     irq_out[g] <= |(lvl_nxt & mask_nxt);
      end
    end else begin : g_direct
      // routing bits outside the allowed band never get set
      always_ff @(posedge clk) begin
        if (rst) irq_out[g] <= 1'b0;
        else     irq_out[g] <= lvl_nxt[g] & rt_nxt[g];
      end
    end
  end
endmodule

// File: rtl/sic_rdmux.sv
module sic_rdmux
  import sic_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int IDX_W   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   rd_idx,
  input  logic [N_LINES-1:0] lvl_eff,
  input  logic [N_LINES-1:0] mask_q,
  input  logic [N_LINES-1:0] rt_q,
  input  logic               soft_q,
  output logic [N_LINES-1:0] rdata_q
);
  logic [N_LINES-1:0] sel;

  always_comb begin
    if (rd_idx == IDX_W'(IDX_MASKED))        sel = lvl_eff & mask_q;
    else if (rd_idx == IDX_W'(IDX_RAW))      sel = lvl_eff;
    else if (rd_idx == IDX_W'(IDX_EN_SET))   sel = mask_q;
    else if (rd_idx == IDX_W'(IDX_SOFT_SET)) sel = {{(N_LINES-1){1'b0}}, soft_q};
    else if (rd_idx == IDX_W'(IDX_RT_SET))   sel = rt_q;
    else                                     sel = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= sel;
  end
endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl #(
  parameter int N_LINES  = 32,
  parameter int ADDR_W   = 12,
  parameter int RT_LO    = 21,
  parameter int RT_HI    = 30,
  parameter int SUM_LINE = 31
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [N_LINES-1:0] bus_wdata,
  output logic [N_LINES-1:0] bus_rdata,
  output logic [N_LINES-1:0] irq_out
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]   word_idx;
  logic               unused_addr_lsbs;
  logic [N_LINES-1:0] level_q;
  logic [N_LINES-1:0] mask_q, rt_q, mask_nxt, rt_nxt;
  logic               soft_q, soft_nxt;
  logic [N_LINES-1:0] lvl_eff, lvl_eff_nxt;

  assign word_idx         = bus_addr[ADDR_W-1:2];
  assign unused_addr_lsbs = ^bus_addr[1:0];

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= irq_in;
  end

  assign lvl_eff     = level_q | {{(N_LINES-1){1'b0}}, soft_q};
  assign lvl_eff_nxt = irq_in  | {{(N_LINES-1){1'b0}}, soft_nxt};

  sic_regs #(
    .N_LINES(N_LINES), .IDX_W(IDX_W), .RT_LO(RT_LO), .RT_HI(RT_HI)
  ) regs_i (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .wr_idx(word_idx), .wr_data(bus_wdata),
    .mask_q(mask_q), .rt_q(rt_q), .soft_q(soft_q),
    .mask_nxt(mask_nxt), .rt_nxt(rt_nxt), .soft_nxt(soft_nxt)
  );

  sic_route #(
    .N_LINES(N_LINES), .SUM_LINE(SUM_LINE)
  ) route_i (
    .clk(clk), .rst(rst), .lvl_nxt(lvl_eff_nxt), .mask_nxt(mask_nxt),
    .rt_nxt(rt_nxt), .irq_out(irq_out)
  );

  sic_rdmux #(
    .N_LINES(N_LINES), .IDX_W(IDX_W)
  ) rdmux_i (
    .clk(clk), .rst(rst), .rd_en(bus_rd), .rd_idx(word_idx), .lvl_eff(lvl_eff),
    .mask_q(mask_q), .rt_q(rt_q), .soft_q(soft_q), .rdata_q(bus_rdata)
  );
endmodule

// File: rtl/sic_checker.sv
module sic_checker #(
  parameter int N_LINES  = 32,
  parameter int ADDR_W   = 12,
  parameter int RT_LO    = 21,
  parameter int RT_HI    = 30,
  parameter int SUM_LINE = 31
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic [N_LINES-1:0] bus_wdata,
  input logic [N_LINES-1:0] irq_out,
  input logic [N_LINES-1:0] level_q,
  input logic [N_LINES-1:0] mask_q,
  input logic [N_LINES-1:0] rt_q,
  input logic               soft_q
);
  logic [ADDR_W-3:0]  idx;
  logic               known_wr;
  logic [N_LINES-1:0] eff, band, low_lines;

  assign idx = bus_addr[ADDR_W-1:2];
  assign known_wr = (idx == 2) || (idx == 3) || (idx == 4) ||
                    (idx == 5) || (idx == 8) || (idx == 9);
  assign eff = level_q | {{(N_LINES-1){1'b0}}, soft_q};

  always_comb begin
    band = '0;
    for (int i = RT_LO; i <= RT_HI; i++) band[i] = 1'b1;
    low_lines = ~band;
    low_lines[SUM_LINE] = 1'b0;
  end

  AST_SUMMARY_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq_out[SUM_LINE] == |(eff & mask_q)); // R5
  AST_EN_SET: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && idx == 2) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata))); // R3
  AST_EN_CLR: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && idx == 3) |=> ((mask_q & $past(bus_wdata)) == '0)); // R4
  AST_RT_BAND_ONLY: assert property (@(posedge clk) disable iff (rst)
    (rt_q & ~band) == '0); // R6
  AST_RT_CLR: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && idx == 9) |=> ((rt_q & $past(bus_wdata)) == '0)); // R7
  AST_ROUTE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (irq_out & band) == (level_q & rt_q & band)); // R8
  AST_LOW_LINES: assert property (@(posedge clk) disable iff (rst)
    (irq_out & low_lines) == '0); // R8
  AST_SOFT_SET: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && idx == 4 && bus_wdata != '0) |=> soft_q); // R9
  AST_SOFT_CLR: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && idx == 5 && bus_wdata != '0) |=> !soft_q); // R9
  AST_UNKNOWN_WR_INERT: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !known_wr) |=> ($stable(mask_q) && $stable(rt_q) && $stable(soft_q))); // R11
endmodule

bind sec_irq_ctrl sic_checker chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .irq_out(irq_out), .level_q(level_q),
  .mask_q(mask_q), .rt_q(rt_q), .soft_q(soft_q)
);

// File: tb/sec_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module sec_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_in = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } rd_item_t;
  rd_item_t rd_q[$];
  logic rd_seen = 1'b0;

  always #2 clk = ~clk;

  sec_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data in the cycle after the strobe
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (rd_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL scoreboard: unexpected read data %h expected none", bus_rdata);
      end else begin
        rd_item_t it;
        it = rd_q.pop_front();
        check(it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic bus_write(logic [11:0] addr, logic [31:0] data);
    @(negedge clk);
    bus_addr = addr; bus_wdata = data; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [9:0] idx, logic [31:0] exp, string tag);
    rd_item_t it;
    @(negedge clk);
    bus_addr = {idx, 2'b00}; bus_rd = 1'b1;
    it.exp = exp; it.tag = tag;
    rd_q.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_inputs(logic [31:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 outputs after reset", irq_out, 32'h0);
    check("R1 rdata after reset", bus_rdata, 32'h0);
    bus_read(10'd2, 32'h0, "R1 mask reset");
    bus_read(10'd8, 32'h0, "R1 routing reset");
    bus_read(10'd4, 32'h0, "R1 soft reset");

    set_inputs(32'h0000_00F0);
    bus_read(10'd1, 32'h0000_00F0, "R2 raw read");
    bus_read(10'd0, 32'h0, "R2 masked read with empty mask");
    check("R5 summary low with empty mask", irq_out, 32'h0);

    bus_write(12'h008, 32'h30);
    check("R5 summary rises after enable", irq_out, 32'h8000_0000);
    bus_read(10'd2, 32'h30, "R3 mask set");
    bus_write(12'h008, 32'h100);
    bus_read(10'd2, 32'h130, "R3 mask OR accumulate");
    bus_read(10'd0, 32'h30, "R2 masked read");

    bus_write(12'h00C, 32'h10);
    bus_read(10'd2, 32'h120, "R4 mask clear bits");
    check("R5 summary held by bit 5", irq_out, 32'h8000_0000);
    bus_write(12'h00C, 32'hFFFF_FFFF);
    check("R4 R5 summary drops after clear all", irq_out, 32'h0);

    bus_write(12'h008, 32'h8);
    set_inputs(32'h8);
    check("R5 summary follows input", irq_out, 32'h8000_0000);
    set_inputs(32'h0);
    check("R5 summary falls with input", irq_out, 32'h0);

    bus_write(12'h020, 32'hFFFF_FFFF);
    bus_read(10'd8, 32'h7FE0_0000, "R6 routing set limited to band");
    set_inputs(32'hFFFF_FFFF);
    check("R8 routed lines follow inputs", irq_out, 32'hFFE0_0000);

    bus_write(12'h024, 32'h0060_0000);
    check("R7 cleared lines drop", irq_out, 32'hFF80_0000);
    bus_read(10'd8, 32'h7F80_0000, "R7 routing clear readback");
    set_inputs(32'h0);
    check("R8 routed lines fall with inputs", irq_out, 32'h0);

    bus_write(12'h010, 32'h0);
    bus_read(10'd4, 32'h0, "R9 zero write does not set soft");
    bus_write(12'h010, 32'h5);
    bus_read(10'd4, 32'h1, "R9 soft set");
    bus_read(10'd1, 32'h1, "R10 soft in raw vector");
    check("R10 soft masked off summary", irq_out, 32'h0);
    bus_write(12'h008, 32'h1);
    check("R10 soft drives summary", irq_out, 32'h8000_0000);
    bus_read(10'd0, 32'h1, "R10 soft in masked vector");
    bus_write(12'h014, 32'h0);
    bus_read(10'd4, 32'h1, "R9 zero clear write ignored");
    bus_write(12'h014, 32'h80);
    bus_read(10'd4, 32'h0, "R9 soft clear");
    check("R9 summary drops after soft clear", irq_out, 32'h0);

    bus_write(12'h018, 32'hFFFF_FFFF);
    bus_write(12'hFFC, 32'hFFFF_FFFF);
    bus_write(12'h000, 32'hFFFF_FFFF);
    bus_write(12'h004, 32'hFFFF_FFFF);
    bus_read(10'd2, 32'h9, "R11 mask untouched by unknown writes");
    bus_read(10'd8, 32'h7F80_0000, "R11 routing untouched by unknown writes");
    bus_read(10'd4, 32'h0, "R11 soft untouched by unknown writes");
    check("R11 outputs quiet after unknown writes", irq_out, 32'h0);
    bus_read(10'd7, 32'h0, "R11 read of index 7");
    bus_read(10'h200, 32'h0, "R11 read of index 0x200");
    bus_write(12'h00B, 32'h40);
    bus_read(10'd2, 32'h49, "R2 low address bits ignored");

    repeat (2) @(negedge clk);
    check("R2 scoreboard drained", 32'(rd_q.size()), 32'h0);
    done = 1'b1;
    finish_run();
  end
endmodule